// File: doc/BRIEF.md
# Precise Register State Unit with Future File

This unit holds the register state of a single-issue, in-order pipeline whose operations finish after 1, 2, 5 or 8 cycles. Because latencies differ, results complete out of program order. The unit keeps two copies of the 32 registers. The working copy takes every result the moment it completes and serves both operand read ports. The committed copy changes only in program order, through an 8-slot completion queue. An exception is therefore precise: the committed copy holds the effect of every instruction older than the faulting one, and of no younger one.

At dispatch, the pipeline hands over a destination register. The unit answers with a slot tag. Functional units later return that tag together with the result value and a fault flag. The oldest slot commits once its result is present and clean. A faulting oldest slot, or an external flush request, moves the control FSM from `ST_RUN` to `ST_RESTORE`. During that one cycle the queue is emptied, the working copy is overwritten from the committed copy, and `exc_taken` is raised. The FSM then always returns to `ST_RUN`.

A per-register table records the youngest in-flight writer of each register. A late result from an older producer therefore never overwrites a younger result in the working copy.

Top module: `precise_regstate`

## Requirements
- R1: After reset both register copies read as zero, `disp_ready` is 1, `disp_tag` is 0 and `exc_taken` is 0.
- R2: Dispatch tags are queue slot indices handed out in order, modulo 8. The first tag is 0 after reset and after every restore.
- R3: With 8 slots outstanding, `disp_ready` is 0 and a dispatch request is ignored: it allocates no slot and advances no tag.
- R4: An accepted writeback with the fault flag clear updates the working copy at the next clock edge, and reads then return the new value.
- R5: A read whose register equals the register being written back in the same cycle returns the incoming value.
- R6: The working copy takes a result only from the youngest in-flight writer of that register. The committed copy still takes every result in program order.
- R7: The oldest slot commits only when its result is present and not faulted, at most one slot per cycle, in program order. `retire_valid` and `retire_rd` report each commit in the cycle it happens.
- R8: A faulted oldest slot causes `exc_taken` to be high for exactly one cycle, two cycles after that slot's writeback cycle. After this, the queue is empty, every register reads its committed value, and younger results are discarded.
- R9: Raising `ext_flush` for one cycle in `ST_RUN` gives a one-cycle `exc_taken` in the next cycle, with the same restore as R8.
- R10: A writeback to a tag with no allocated slot has no effect on any register and causes no commit.
- R11: A faulted result in a slot that is not the oldest raises nothing until every older slot has committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_rd | input | 5 | Destination register of the dispatched instruction |
| disp_ready | output | 1 | Queue can accept a dispatch this cycle |
| disp_tag | output | 3 | Tag given to a dispatch in this cycle |
| wb_valid | input | 1 | Result returning |
| wb_tag | input | 3 | Tag of the returning result |
| wb_data | input | 32 | Result value |
| wb_exc | input | 1 | The returning operation faulted |
| rs1_idx | input | 5 | Read port 1 register index |
| rs1_data | output | 32 | Read port 1 value |
| rs2_idx | input | 5 | Read port 2 register index |
| rs2_data | output | 32 | Read port 2 value |
| ext_flush | input | 1 | Request for a flush and restore |
| exc_taken | output | 1 | One-cycle pulse while the restore is performed |
| retire_valid | output | 1 | A slot commits this cycle |
| retire_rd | output | 5 | Register written by the committing slot |

## Verification
The main path is tried with a sweep that dispatches, writes back and reads every one of the 32 registers in turn. This separates indexing faults from tag-wrap faults, and same-cycle bypass from registered reads. A full queue is then written back in reverse order, which separates commit in completion order from commit in program order and exposes a dispatch taken while full. Two writers to one register, completing oldest-last, distinguish a working copy guarded by the youngest-writer table from an unguarded one. A fault placed behind a slower older instruction, together with an external flush, shows whether the committed copy holds exactly the older results and whether the restore timing is right.

// File: rtl/fut_pkg.sv
package fut_pkg;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RESTORE = 1'b1
    } rs_state_e;

endpackage

// File: rtl/fut_rob.sv
module fut_rob #(
    parameter int DEPTH = 8,
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    localparam int TW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            alloc,
    input  logic [RW-1:0]   alloc_rd,
    output logic [TW-1:0]   alloc_tag,
    output logic            full,
    input  logic            wb_en,
    input  logic            wb_valid,
    input  logic [TW-1:0]   wb_tag,
    input  logic [XLEN-1:0] wb_data,
    input  logic            wb_exc,
    output logic            wb_hit,
    output logic [RW-1:0]   wb_rd,
    input  logic            retire,
    output logic            head_valid,
    output logic            head_done,
    output logic            head_exc,
    output logic [RW-1:0]   head_rd,
    output logic [TW-1:0]   head_tag,
    output logic [XLEN-1:0] head_data
);

    localparam logic [TW:0] CNT_MAX = (TW+1)'(DEPTH);

    logic            valid_q [DEPTH];
    logic            done_q  [DEPTH];
    logic            exc_q   [DEPTH];
    logic [RW-1:0]   rd_q    [DEPTH];
    logic [XLEN-1:0] data_q  [DEPTH];
    logic [TW-1:0]   head_q, tail_q;
    logic [TW:0]     count_q;

    // slot bookkeeping: allocation at tail, completion by tag, commit at head
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                valid_q[i] <= 1'b0;
                done_q[i]  <= 1'b0;
                exc_q[i]   <= 1'b0;
                rd_q[i]    <= '0;
                data_q[i]  <= '0;
            end
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc) begin
                valid_q[tail_q] <= 1'b1;
                done_q[tail_q]  <= 1'b0;
                exc_q[tail_q]   <= 1'b0;
                rd_q[tail_q]    <= alloc_rd;
                tail_q          <= tail_q + 1'b1;
            end
            if (wb_hit) begin
                done_q[wb_tag] <= 1'b1;
                exc_q[wb_tag]  <= wb_exc;
                data_q[wb_tag] <= wb_data;
            end
            if (retire) begin
                valid_q[head_q] <= 1'b0;
                head_q          <= head_q + 1'b1;
            end
            count_q <= count_q + (TW+1)'(alloc) - (TW+1)'(retire);
        end
    end

    always_comb begin
        full       = (count_q == CNT_MAX);
        alloc_tag  = tail_q;
        wb_hit     = wb_en && wb_valid && valid_q[wb_tag] && !done_q[wb_tag];
        wb_rd      = rd_q[wb_tag];
        head_valid = valid_q[head_q];
        head_done  = done_q[head_q];
        head_exc   = exc_q[head_q];
        head_rd    = rd_q[head_q];
        head_tag   = head_q;
        head_data  = data_q[head_q];
    end

    p_alloc_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_MAX);
    p_retire_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (head_valid && head_done && !head_exc));
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0 && !head_valid));

endmodule

// File: rtl/fut_files.sv
module fut_files #(
    parameter int DEPTH = 8,
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    localparam int TW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restore,
    input  logic            disp_we,
    input  logic [RW-1:0]   disp_rd,
    input  logic [TW-1:0]   disp_tag,
    input  logic            wb_hit,
    input  logic            wb_exc,
    input  logic [TW-1:0]   wb_tag,
    input  logic [RW-1:0]   wb_rd,
    input  logic [XLEN-1:0] wb_data,
    input  logic            ret_we,
    input  logic [RW-1:0]   ret_rd,
    input  logic [TW-1:0]   ret_tag,
    input  logic [XLEN-1:0] ret_data,
    input  logic [RW-1:0]   rs1_idx,
    output logic [XLEN-1:0] rs1_data,
    input  logic [RW-1:0]   rs2_idx,
    output logic [XLEN-1:0] rs2_data
);

    logic [XLEN-1:0] fut_q  [NREG];
    logic [XLEN-1:0] arch_q [NREG];
    logic            lw_valid_q [NREG];
    logic [TW-1:0]   lw_tag_q   [NREG];
    logic            fut_we;
    logic            files_match;

    // youngest-writer guard keeps late older results out of the working copy
    always_comb begin
        fut_we = wb_hit && !wb_exc && lw_valid_q[wb_rd] && (lw_tag_q[wb_rd] == wb_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                fut_q[i]      <= '0;
                lw_valid_q[i] <= 1'b0;
                lw_tag_q[i]   <= '0;
            end
        end else if (restore) begin
            for (int i = 0; i < NREG; i++) begin
                fut_q[i]      <= arch_q[i];
                lw_valid_q[i] <= 1'b0;
            end
        end else begin
            if (fut_we) begin
                fut_q[wb_rd] <= wb_data;
            end
            if (ret_we && lw_valid_q[ret_rd] && (lw_tag_q[ret_rd] == ret_tag)) begin
                lw_valid_q[ret_rd] <= 1'b0;
            end
            if (disp_we) begin
                lw_valid_q[disp_rd] <= 1'b1;
                lw_tag_q[disp_rd]   <= disp_tag;
            end
        end
    end

    // committed copy: program-order writes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                arch_q[i] <= '0;
            end
        end else if (ret_we) begin
            arch_q[ret_rd] <= ret_data;
        end
    end

    always_comb begin
        rs1_data = (fut_we && rs1_idx == wb_rd) ? wb_data : fut_q[rs1_idx];
        rs2_data = (fut_we && rs2_idx == wb_rd) ? wb_data : fut_q[rs2_idx];
    end

    always_comb begin
        files_match = 1'b1;
        for (int i = 0; i < NREG; i++) begin
            if (fut_q[i] != arch_q[i]) begin
                files_match = 1'b0;
            end
        end
    end

    p_restore_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> files_match);
    p_no_commit_in_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore |-> !ret_we);

endmodule

// File: rtl/fut_ctrl.sv
module fut_ctrl
    import fut_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_flush,
    input  logic full,
    input  logic head_valid,
    input  logic head_done,
    input  logic head_exc,
    output logic restore,
    output logic disp_ready,
    output logic wb_en,
    output logic retire,
    output logic exc_taken
);

    rs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ext_flush || (head_valid && head_done && head_exc)) begin
                    state_d = ST_RESTORE;
                end
            end
            ST_RESTORE: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        restore    = 1'b0;
        disp_ready = 1'b0;
        wb_en      = 1'b0;
        retire     = 1'b0;
        exc_taken  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                disp_ready = !full;
                wb_en      = 1'b1;
                retire     = head_valid && head_done && !head_exc;
            end
            ST_RESTORE: begin
                restore   = 1'b1;
                exc_taken = 1'b1;
            end
            default: ;
        endcase
    end

    p_exc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> !exc_taken);
    p_no_dispatch_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (!disp_ready && !retire));
    p_flush_reacts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flush && !exc_taken) |=> exc_taken);

endmodule

// File: rtl/precise_regstate.sv
module precise_regstate #(
    parameter int DEPTH = 8,
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    localparam int TW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [RW-1:0]   disp_rd,
    output logic            disp_ready,
    output logic [TW-1:0]   disp_tag,
    input  logic            wb_valid,
    input  logic [TW-1:0]   wb_tag,
    input  logic [XLEN-1:0] wb_data,
    input  logic            wb_exc,
    input  logic [RW-1:0]   rs1_idx,
    output logic [XLEN-1:0] rs1_data,
    input  logic [RW-1:0]   rs2_idx,
    output logic [XLEN-1:0] rs2_data,
    input  logic            ext_flush,
    output logic            exc_taken,
    output logic            retire_valid,
    output logic [RW-1:0]   retire_rd
);

    logic            restore, wb_en, retire, full, alloc;
    logic            wb_hit;
    logic [RW-1:0]   wb_rd;
    logic            head_valid, head_done, head_exc;
    logic [RW-1:0]   head_rd;
    logic [TW-1:0]   head_tag;
    logic [XLEN-1:0] head_data;

    assign alloc        = disp_valid && disp_ready;
    assign retire_valid = retire;
    assign retire_rd    = head_rd;

    fut_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_flush  (ext_flush),
        .full       (full),
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_exc   (head_exc),
        .restore    (restore),
        .disp_ready (disp_ready),
        .wb_en      (wb_en),
        .retire     (retire),
        .exc_taken  (exc_taken)
    );

    fut_rob #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) rob_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (restore),
        .alloc      (alloc),
        .alloc_rd   (disp_rd),
        .alloc_tag  (disp_tag),
        .full       (full),
        .wb_en      (wb_en),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_data    (wb_data),
        .wb_exc     (wb_exc),
        .wb_hit     (wb_hit),
        .wb_rd      (wb_rd),
        .retire     (retire),
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_exc   (head_exc),
        .head_rd    (head_rd),
        .head_tag   (head_tag),
        .head_data  (head_data)
    );

    fut_files #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) files_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restore  (restore),
        .disp_we  (alloc),
        .disp_rd  (disp_rd),
        .disp_tag (disp_tag),
        .wb_hit   (wb_hit),
        .wb_exc   (wb_exc),
        .wb_tag   (wb_tag),
        .wb_rd    (wb_rd),
        .wb_data  (wb_data),
        .ret_we   (retire),
        .ret_rd   (head_rd),
        .ret_tag  (head_tag),
        .ret_data (head_data),
        .rs1_idx  (rs1_idx),
        .rs1_data (rs1_data),
        .rs2_idx  (rs2_idx),
        .rs2_data (rs2_data)
    );

    p_one_exc_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_hit && wb_exc && (wb_tag != head_tag)) |=> !exc_taken);

endmodule

// File: tb/precise_regstate_tb_top.sv
module precise_regstate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid;
    logic [4:0]  disp_rd;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        wb_valid;
    logic [2:0]  wb_tag;
    logic [31:0] wb_data;
    logic        wb_exc;
    logic [4:0]  rs1_idx, rs2_idx;
    logic [31:0] rs1_data, rs2_data;
    logic        ext_flush;
    logic        exc_taken;
    logic        retire_valid;
    logic [4:0]  retire_rd;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_reg [32];

    always #4 clk = ~clk;

    precise_regstate dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_rd(disp_rd), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
        .rs1_idx(rs1_idx), .rs1_data(rs1_data), .rs2_idx(rs2_idx), .rs2_data(rs2_data),
        .ext_flush(ext_flush), .exc_taken(exc_taken),
        .retire_valid(retire_valid), .retire_rd(retire_rd)
    );

    function automatic logic [31:0] sweep_val(input int i);
        return 32'h1000_0000 | (32'(i) << 8) | 32'(i * 3);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic dispatch(input int rd, input int exp_tag, input string req);
        disp_valid = 1'b1;
        disp_rd    = 5'(rd);
        #1;
        check(req, {31'd0, disp_ready}, 32'd1);
        check(req, {29'd0, disp_tag}, 32'(exp_tag));
        step();
        disp_valid = 1'b0;
    endtask

    task automatic writeback(input int tag, input logic [31:0] val, input logic exc);
        wb_valid = 1'b1;
        wb_tag   = 3'(tag);
        wb_data  = val;
        wb_exc   = exc;
        step();
        wb_valid = 1'b0;
        wb_exc   = 1'b0;
    endtask

    task automatic read_chk(input int idx, input logic [31:0] exp, input string req);
        rs1_idx = 5'(idx);
        #1;
        check(req, rs1_data, exp);
    endtask

    task automatic flush_pulse(input string req);
        ext_flush = 1'b1;
        step();
        ext_flush = 1'b0;
        #1;
        check(req, {31'd0, exc_taken}, 32'd1);
        step();
        #1;
        check(req, {31'd0, exc_taken}, 32'd0);
        check(req, {29'd0, disp_tag}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; disp_valid = 1'b0; disp_rd = '0;
        wb_valid = 1'b0; wb_tag = '0; wb_data = '0; wb_exc = 1'b0;
        rs1_idx = '0; rs2_idx = '0; ext_flush = 1'b0;
        for (int i = 0; i < 32; i++) exp_reg[i] = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 ready", {31'd0, disp_ready}, 32'd1);
        check("R1 tag", {29'd0, disp_tag}, 32'd0);
        check("R1 exc", {31'd0, exc_taken}, 32'd0);
        for (int i = 0; i < 32; i++) read_chk(i, 32'd0, "R1 reg");

        // sweep all registers: R2 tags, R5 bypass, R4 registered update
        for (int i = 0; i < 32; i++) begin
            dispatch(i, i % 8, "R2 tag order");
            rs2_idx  = 5'(i);
            wb_valid = 1'b1; wb_tag = 3'(i % 8); wb_data = sweep_val(i); wb_exc = 1'b0;
            #1;
            check("R5 bypass", rs2_data, sweep_val(i));
            step();
            wb_valid = 1'b0;
            read_chk(i, sweep_val(i), "R4 update");
            exp_reg[i] = sweep_val(i);
        end
        repeat (2) step();

        // R9 flush restores the committed copy, which holds every swept value
        flush_pulse("R9 flush");
        for (int i = 0; i < 32; i++) read_chk(i, exp_reg[i], "R9 committed");

        // R3 full queue, R7 program-order commit after reverse completion
        for (int k = 0; k < 8; k++) dispatch(10 + k, k, "R2 fill");
        #1;
        check("R3 full", {31'd0, disp_ready}, 32'd0);
        disp_valid = 1'b1; disp_rd = 5'd30;
        step();
        disp_valid = 1'b0;
        for (int k = 7; k >= 1; k--) begin
            writeback(k, 32'hC000_0000 + 32'(k), 1'b0);
            check("R7 head pending", {31'd0, retire_valid}, 32'd0);
            read_chk(10 + k, 32'hC000_0000 + 32'(k), "R4 out of order");
        end
        writeback(0, 32'hC000_0000, 1'b0);
        for (int k = 0; k < 8; k++) begin
            check("R7 commit valid", {31'd0, retire_valid}, 32'd1);
            check("R7 commit order", {27'd0, retire_rd}, 32'(10 + k));
            exp_reg[10 + k] = 32'hC000_0000 + 32'(k);
            step();
        end
        check("R3 ignored dispatch", {29'd0, disp_tag}, 32'd0);
        read_chk(30, exp_reg[30], "R3 ignored dispatch");

        // R6 two writers of r20, older completes last
        dispatch(20, 0, "R6 first");
        dispatch(20, 1, "R6 second");
        writeback(1, 32'hAAAA_0001, 1'b0);
        writeback(0, 32'h5555_0000, 1'b0);
        read_chk(20, 32'hAAAA_0001, "R6 youngest wins");
        repeat (3) step();
        flush_pulse("R9 flush");
        read_chk(20, 32'hAAAA_0001, "R6 committed order");
        exp_reg[20] = 32'hAAAA_0001;

        // R11 fault behind an older slot, then R8 precise restore
        dispatch(21, 0, "R8 a");
        dispatch(22, 1, "R8 b");
        dispatch(23, 2, "R8 c");
        writeback(1, 32'hDEAD_0022, 1'b1);
        writeback(2, 32'hB0B0_0023, 1'b0);
        read_chk(23, 32'hB0B0_0023, "R4 younger visible");
        for (int k = 0; k < 3; k++) begin
            check("R11 waits", {31'd0, exc_taken}, 32'd0);
            step();
        end
        writeback(0, 32'hB0B0_0021, 1'b0);
        check("R8 timing", {31'd0, exc_taken}, 32'd0);
        step();
        check("R8 timing", {31'd0, exc_taken}, 32'd0);
        step();
        check("R8 pulse", {31'd0, exc_taken}, 32'd1);
        step();
        check("R8 pulse end", {31'd0, exc_taken}, 32'd0);
        check("R8 ready", {31'd0, disp_ready}, 32'd1);
        check("R8 tag reset", {29'd0, disp_tag}, 32'd0);
        exp_reg[21] = 32'hB0B0_0021;
        read_chk(21, exp_reg[21], "R8 older kept");
        read_chk(22, exp_reg[22], "R8 faulted dropped");
        read_chk(23, exp_reg[23], "R8 younger dropped");

        // R10 stray writeback to an empty queue
        writeback(5, 32'hFFFF_EEEE, 1'b0);
        check("R10 no commit", {31'd0, retire_valid}, 32'd0);
        for (int i = 0; i < 32; i++) read_chk(i, exp_reg[i], "R10 untouched");
        step();
        check("R10 no commit", {31'd0, retire_valid}, 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule